// File: doc/BRIEF.md
# Paired-Mode Output Compare Unit

This block holds six compare channels that share one up-counting timer. On every counted cycle, each channel checks the timer value against its own compare register. On a hit, the channel inverts its output flip-flop and raises its match flag. The channels are grouped as three pairs: 0/1, 2/3 and 4/5. Each pair has a mode bit. With the mode bit set, the odd output of the pair inverts on a hit from either channel of the pair. The even value then sets one edge of a pulse and the odd value sets the other, so a single pin carries the pulse.

Software loads compare values and pair control words through a single-cycle write port. A match flag is cleared by writing 0 to it. An interrupt request is the flag gated by the channel's enable bit. A per-channel output enable masks the pin to 0. The output flip-flop keeps running while the pin is masked.

Top module: `paired_compare_unit`

## Requirements
- R1: After reset the timer value, all pins, all flags and all interrupt requests are 0.
- R2: The timer adds 1 on each clock with `cnt_en` high. It holds its value when `cnt_en` is low, and it wraps from 0xFFFF to 0x0000.
- R3: `cnt_clr` high for one clock sets the timer and all six output flip-flops to 0. This takes priority over counting, and no match is taken in that cycle.
- R4: A match on an even channel (0, 2, 4) inverts that channel's output on the next edge, whatever the pair's mode bit.
- R5: With the pair mode bit at 0, the odd output inverts only on a match of its own compare register.
- R6: With the pair mode bit at 1, the odd output inverts on a match of either register of its pair. When both registers match in the same cycle, it inverts only once.
- R7: A match is a cycle with `cnt_en` high, `cnt_clr` low and the timer equal to the compare value. A match sets the channel flag at the next edge, and `irq[i]` equals flag i ANDed with interrupt enable i.
- R8: Writing 0 to a flag bit clears it. Writing 1 to a flag bit has no effect. When a match and a clearing write fall in the same cycle, the flag ends up set.
- R9: With output enable 0, the pin is 0, but its flip-flop keeps inverting on matches. Setting the enable later shows the current flip-flop state.
- R10: Write address map:
  - Addresses 0 to 5 are the compare registers of channels 0 to 5.
  - Addresses 6, 7 and 8 are the control words of pairs 0/1, 2/3 and 4/5.
  - In a control word, bit 0 is the mode bit, bits 1 and 2 are the even and odd interrupt enables, bits 3 and 4 are the even and odd output enables, and bits 6 and 7 are the even and odd flags.
  - Writes to addresses 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Timer count enable |
| cnt_clr | input | 1 | Synchronous clear of timer and output flip-flops |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Current timer value |
| pin_out | output | 6 | Compare outputs after output-enable masking |
| flags | output | 6 | Match flags |
| irq | output | 6 | Interrupt requests |

## Verification
Two cases are hard to reach from the ports:
- Both registers of a pair hitting on one cycle in paired mode. The stimulus loads the same value into channels 2 and 3, clears the timer and lets it run, so both hits fall on the same tick.
- A hardware flag set racing a software clear. The bench polls `count` until it equals the channel 0 compare value, then issues the clearing write in exactly that cycle.

A behavioural model follows every clock, including a full wrap of the timer.

// File: rtl/paired_compare_unit.sv
module paired_compare_unit #(
  parameter int CW    = 16,
  parameter int PAIRS = 3,
  parameter int AW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              cnt_clr,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [CW-1:0]     count,
  output logic [2*PAIRS-1:0] pin_out,
  output logic [2*PAIRS-1:0] flags,
  output logic [2*PAIRS-1:0] irq
);
  localparam int NCH = 2 * PAIRS;

  logic [NCH-1:0][CW-1:0] cmp;
  logic [PAIRS-1:0]       mode;
  logic [NCH-1:0]         ie, oe, flag, tog, hit, flip;
  logic                   run;

  assign run = cnt_en & ~cnt_clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       count <= '0;
    else if (cnt_clr) count <= '0;
    else if (cnt_en)  count <= count + 1'b1;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hit[c] = run && (count == cmp[c]);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cmp[c] <= '0;
      else if (wr_en && wr_addr == AW'(c)) cmp[c] <= wr_data;
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic ctl_wr;
    assign ctl_wr = wr_en && wr_addr == AW'(NCH + p);
    assign flip[2*p]   = hit[2*p];
    assign flip[2*p+1] = hit[2*p+1] | (mode[p] & hit[2*p]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        mode[p] <= 1'b0;
        ie[2*p+1 -: 2] <= 2'b00;
        oe[2*p+1 -: 2] <= 2'b00;
      end else if (ctl_wr) begin
        mode[p] <= wr_data[0];
        ie[2*p+1 -: 2] <= wr_data[2:1];
        oe[2*p+1 -: 2] <= wr_data[4:3];
      end

    for (genvar k = 0; k < 2; k++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                       flag[2*p+k] <= 1'b0;
        else if (hit[2*p+k])              flag[2*p+k] <= 1'b1;
        else if (ctl_wr && !wr_data[6+k]) flag[2*p+k] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tog <= '0;
    else if (cnt_clr) tog <= '0;
    else              tog <= tog ^ flip;

  assign pin_out = tog & oe;
  assign flags   = flag;
  assign irq     = flag & ie;
endmodule

// File: rtl/paired_compare_unit_chk.sv
module paired_compare_unit_chk #(
  parameter int CW    = 16,
  parameter int PAIRS = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cnt_en,
  input logic                       cnt_clr,
  input logic [CW-1:0]              count,
  input logic [2*PAIRS-1:0][CW-1:0] cmp,
  input logic [PAIRS-1:0]           mode,
  input logic [2*PAIRS-1:0]         tog,
  input logic [2*PAIRS-1:0]         flag,
  input logic [2*PAIRS-1:0]         pin_out
);
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count == '0 && pin_out == '0)); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_clr && count == '1) |=> count == '0); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_clr) |=> $stable(count)); // R2
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_clr && count == cmp[0]) |=> flag[0]); // R7
  AST_EVEN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_clr && count == cmp[0]) |=> tog[0] != $past(tog[0])); // R4
  AST_ODD_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !mode[0] && !(cnt_en && count == cmp[1])) |=> $stable(tog[1])); // R5
  AST_PAIR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_clr && mode[0] && count == cmp[0] && count == cmp[1])
      |=> tog[1] != $past(tog[1])); // R6
endmodule

bind paired_compare_unit paired_compare_unit_chk #(.CW(CW), .PAIRS(PAIRS)) u_chk (.*);

// File: tb/paired_compare_unit_bench.sv
`timescale 1ns/1ps
module paired_compare_unit_bench;
  logic clk = 0, rst_n = 0, cnt_en = 0, cnt_clr = 0, wr_en = 0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [5:0] pin_out, flags, irq;
  int checks = 0, errors = 0, cyc = 0;

  paired_compare_unit u_paired_compare_unit (.*);

  always #10 clk = ~clk;

  logic [15:0] m_cnt, m_cmp [6];
  logic [5:0]  m_tog, m_flag, m_ie, m_oe, mt;
  logic [2:0]  m_mode;
  logic        m_run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_tog = 0; m_flag = 0; m_ie = 0; m_oe = 0; m_mode = 0;
      for (int c = 0; c < 6; c++) m_cmp[c] = 0;
    end else begin
      m_run = cnt_en && !cnt_clr;
      for (int c = 0; c < 6; c++) mt[c] = m_run && (m_cnt == m_cmp[c]);
      for (int p = 0; p < 3; p++) begin
        if (mt[2*p]) m_tog[2*p] = ~m_tog[2*p];
        if (mt[2*p+1] || (m_mode[p] && mt[2*p])) m_tog[2*p+1] = ~m_tog[2*p+1];
      end
      if (cnt_clr) m_tog = 0;
      if (wr_en && wr_addr < 6) m_cmp[wr_addr] = wr_data;
      if (wr_en && wr_addr >= 6 && wr_addr <= 8) begin
        int p;
        p = wr_addr - 6;
        m_mode[p] = wr_data[0];
        m_ie[2*p] = wr_data[1]; m_ie[2*p+1] = wr_data[2];
        m_oe[2*p] = wr_data[3]; m_oe[2*p+1] = wr_data[4];
        if (!wr_data[6]) m_flag[2*p] = 0;
        if (!wr_data[7]) m_flag[2*p+1] = 0;
      end
      m_flag = m_flag | mt;
      if (cnt_clr) m_cnt = 0;
      else if (cnt_en) m_cnt = m_cnt + 1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R2 timer vs model", count, m_cnt);
    check("R4 pins vs model", pin_out, m_tog & m_oe);
    check("R7 flags vs model", flags, m_flag);
    check("R7 irq vs model", irq, m_flag & m_ie);
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #5; end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick(1); wr_en = 0;
  endtask

  task automatic clr1();
    cnt_clr = 1; tick(1); cnt_clr = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog R2 actual %0d cycles expected under 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] sp, sf;
    tick(2); rst_n = 1; tick(1);
    check("R1 count", count, 0); check("R1 pins", pin_out, 0);
    check("R1 flags", flags, 0); check("R1 irq", irq, 0);

    wr(0, 10); wr(1, 20); wr(6, 16'h1E);
    clr1(); cnt_en = 1; tick(30);
    check("R4 even pin0 one flip", pin_out[0], 1);
    check("R5 odd pin1 own match only", pin_out[1], 1);
    check("R7 flags 1:0", flags[1:0], 2'b11);
    check("R7 irq 1:0", irq[1:0], 2'b11);
    wr(6, 16'hDE);
    check("R8 writing 1 keeps flags", flags[1:0], 2'b11);
    wr(6, 16'h1E);
    check("R8 writing 0 clears flags", flags[1:0], 2'b00);

    cnt_en = 0; clr1(); wr(6, 16'h1F); cnt_en = 1; tick(30);
    check("R6 paired pin1 two flips", pin_out[1], 0);
    check("R4 pin0 mode independent", pin_out[0], 1);

    cnt_en = 0; wr(2, 5); wr(3, 5); wr(7, 16'h19); wr(4, 8); wr(8, 16'h00);
    clr1(); cnt_en = 1; tick(10);
    check("R6 coincident hit flips once", pin_out[3], 1);
    check("R4 pin2", pin_out[2], 1);
    check("R9 masked pin4 low", pin_out[4], 0);
    wr(8, 16'h08);
    check("R9 unmasked pin4 shows flop", pin_out[4], 1);

    cnt_en = 0; clr1(); wr(6, 16'h1F); cnt_en = 1;
    while (count != 16'd10) tick(1);
    wr(6, 16'h1F);
    check("R8 set wins over clear", flags[0], 1);

    sp = pin_out; sf = flags; cnt_en = 0;
    wr(12, 16'hFFFF); wr(9, 16'h0000);
    check("R10 unmapped write pins", pin_out, sp);
    check("R10 unmapped write flags", flags, sf);
    cnt_en = 1; tick(3);

    clr1();
    check("R3 clear count", count, 0); check("R3 clear pins", pin_out, 0);
    cnt_en = 0; tick(3);
    check("R2 hold", count, 0);
    cnt_en = 1;
    while (count != 16'hFFFF) tick(1);
    tick(1);
    check("R2 wrap", count, 0);
    cnt_en = 0; tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule